// File: doc/BRIEF.md
# SAR Conversion Clock Sequencer

This block times a successive-approximation converter. It holds the converter in a sampling (acquisition) phase until a conversion request arrives and the minimum sampling time has passed. It then drives a conversion phase of a fixed number of conversion-clock periods and returns to sampling. The conversion clock comes from one of two sources. One is a free-running internal oscillator that is gated so it runs only while a conversion is pending or in progress, unless an automatic mode asks for it to stay on. The other is the external serial clock divided by two, which keeps conversions aligned to the serial interface.

The design runs on one fast system clock. The serial clock, the oscillator stand-in and the active-low start input are sampled as levels, and their edges are detected. Each period of the conversion clock is handled as a one-cycle tick. The channel register is loaded by a command write in manual channel mode. In sequenced channel mode it steps to the next channel after each conversion.

Top module: `sar_clock_sequencer`

## Requirements
- R1: With the serial source active, the conversion clock output changes level on every detected serial-clock rising edge, so it runs at half the serial-clock frequency.
- R2: A conversion (busy high) lasts exactly CONV_CYCLES (default 18) conversion-clock periods: 36 serial-clock rising edges with the serial source, or 18 oscillator rising edges with the internal source.
- R3: A conversion is armed only after at least ACQ_MIN (default 3) conversion-clock rising edges have been counted since sampling restarted. Sampling restarts at reset, at the end of a conversion, and on an accepted channel command.
- R4: The oscillator enable output is high whenever a conversion is armed or busy. While sampling it follows the auto-mode input, so it is low when auto mode is 0.
- R5: A falling edge (1 to 0) on the active-low start input requests a conversion. Holding the input low does not request further conversions.
- R6: A request that arrives before the sampling minimum is met is remembered and honoured once the minimum is reached.
- R7: Busy rises on the first conversion-clock rising edge after the conversion is armed. It falls in the same cycle that the done output pulses high for exactly one system cycle. After reset, busy=0, done=0, sampling=1 and channel=0.
- R8: A start request made while a conversion is armed or busy is discarded and does not cause a later conversion.
- R9: The clock-source select input is sampled only during the sampling phase. A change while a conversion is armed or busy does not alter that conversion.
- R10: The divide-by-two flop is cleared when a conversion is armed, so with the serial source the first conversion-clock edge of every conversion is a low-to-high edge (the conversion clock reads 1 when busy rises).
- R11: With channel mode input chanSeqAuto=0 (manual), a command write during sampling loads cmdChannel into the channel output and restarts the sampling minimum.
- R12: With chanSeqAuto=1 (sequenced), command writes are ignored. The channel output increments by one, modulo NUM_CH (default 8), when each conversion ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than both clock sources |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | Serial clock, sampled as a level |
| oscIn | input | 1 | Free-running internal oscillator stand-in |
| startN | input | 1 | Active-low conversion start; a falling edge requests a conversion |
| srcSelSerial | input | 1 | 1 selects the serial clock divided by two, 0 selects the internal oscillator |
| autoMode | input | 1 | Keeps the oscillator enabled while sampling |
| chanSeqAuto | input | 1 | 0 selects manual channel mode, 1 selects sequenced channel mode |
| cmdWrite | input | 1 | One-cycle channel command strobe |
| cmdChannel | input | CH_W | Channel number carried by the command |
| convClk | output | 1 | Conversion clock |
| oscEnable | output | 1 | Internal oscillator enable |
| busy | output | 1 | Conversion in progress |
| sampling | output | 1 | Acquisition phase active |
| convDone | output | 1 | One-cycle pulse at the end of a conversion |
| channel | output | CH_W | Latched channel number |

## Verification
The sequencer is tried with the serial source and with the internal source, and with auto mode both off and on. This shows whether the divider and the oscillator gating are kept apart, and whether conversion length is counted in the right clock. A start issued right after a channel command tells a held-off request apart from one that is dropped or honoured too early. A start issued during a conversion tells a discarded request apart from one that is queued. Flipping the source select mid-conversion and running back-to-back sequenced conversions show whether the source is frozen during a conversion and whether the channel advances at the right point.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    PH_ACQ   = 2'd0,
    PH_ARMED = 2'd1,
    PH_CONV  = 2'd2
  } seqPhase_t;

  typedef struct packed {
    logic clearToggle;
    logic acqRestart;
    logic cntLoad;
    logic cntInc;
    logic chanLoad;
    logic chanAdvance;
    logic srcUpdate;
  } seqStrobes_t;

endpackage

// File: rtl/sar_seq_edge.sv
module sar_seq_edge #(
  parameter bit IDLE_HIGH = 1'b0,
  parameter bit FALLING   = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic pulse
);

  logic prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= IDLE_HIGH;
    else       prevQ <= din;
  end

  generate
    if (FALLING) begin : g_fall
      assign pulse = prevQ & ~din;
    end else begin : g_rise
      assign pulse = din & ~prevQ;
    end
  endgenerate

endmodule

// File: rtl/sar_seq_datapath.sv
module sar_seq_datapath
  import sar_seq_pkg::*;
#(
  parameter int CONV_CYCLES = 18,
  parameter int ACQ_MIN     = 3,
  parameter int NUM_CH      = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ACQ_W = $clog2(ACQ_MIN + 1),
  localparam int CNT_W = $clog2(CONV_CYCLES + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sclkIn,
  input  logic            oscIn,
  input  logic            startN,
  input  logic            srcSelSerial,
  input  logic [CH_W-1:0] cmdChannel,
  input  seqStrobes_t     strobes,
  input  logic            oscEnable,
  output logic            cclkTick,
  output logic            startFall,
  output logic            acqMet,
  output logic            convLast,
  output logic            convClk,
  output logic [CH_W-1:0] channel
);

  localparam int NUM_EDGE = 3;

  logic [NUM_EDGE-1:0] rawIn;
  logic [NUM_EDGE-1:0] edgeHit;
  logic sclkRise, oscRise;
  logic srcSerialQ;
  logic toggleQ;
  logic [ACQ_W-1:0] acqCnt;
  logic [CNT_W-1:0] convCnt;
  logic [CH_W-1:0]  chanQ;

  // index 0: serial clock, 1: oscillator, 2: active-low start
  assign rawIn = {startN, oscIn, sclkIn};

  for (genvar i = 0; i < NUM_EDGE; i++) begin : g_edge
    localparam bit IS_START = (i == NUM_EDGE - 1);
    sar_seq_edge #(
      .IDLE_HIGH(IS_START),
      .FALLING  (IS_START)
    ) u_edge (
      .clk  (clk),
      .rstN (rstN),
      .din  (rawIn[i]),
      .pulse(edgeHit[i])
    );
  end

  assign sclkRise  = edgeHit[0];
  assign oscRise   = edgeHit[1];
  assign startFall = edgeHit[2];

  // clock source is captured only while sampling
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  srcSerialQ <= 1'b0;
    else if (strobes.srcUpdate) srcSerialQ <= srcSelSerial;
  end

  // divide-by-two flop on the serial clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        toggleQ <= 1'b0;
    else if (strobes.clearToggle)     toggleQ <= 1'b0;
    else if (srcSerialQ && sclkRise)  toggleQ <= ~toggleQ;
  end

  // one tick per conversion-clock rising edge
  assign cclkTick = srcSerialQ ? (sclkRise & ~toggleQ) : oscRise;
  assign convClk  = srcSerialQ ? toggleQ : (oscIn & oscEnable);

  // saturating sampling-time counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                           acqCnt <= '0;
    else if (strobes.acqRestart)                         acqCnt <= '0;
    else if (cclkTick && (acqCnt != ACQ_W'(ACQ_MIN)))    acqCnt <= acqCnt + 1'b1;
  end
  assign acqMet = (acqCnt == ACQ_W'(ACQ_MIN));

  // conversion period counter, 1..CONV_CYCLES
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               convCnt <= '0;
    else if (strobes.cntLoad) convCnt <= CNT_W'(1);
    else if (strobes.cntInc)  convCnt <= convCnt + 1'b1;
  end
  assign convLast = (convCnt == CNT_W'(CONV_CYCLES));

  // channel register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    chanQ <= '0;
    else if (strobes.chanLoad)    chanQ <= cmdChannel;
    else if (strobes.chanAdvance) chanQ <= (chanQ == CH_W'(NUM_CH - 1)) ? '0 : chanQ + 1'b1;
  end
  assign channel = chanQ;

  assert_toggle_follows_sclk_R1: assert property (@(posedge clk) disable iff (!rstN)
    (srcSerialQ && sclkRise && !strobes.clearToggle) |=> (toggleQ != $past(toggleQ)));

  assert_toggle_cleared_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearToggle |=> !toggleQ);

  assert_src_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.srcUpdate |=> $stable(srcSerialQ));

  assert_count_bounded_R2: assert property (@(posedge clk) disable iff (!rstN)
    convCnt <= CNT_W'(CONV_CYCLES));

endmodule

// File: rtl/sar_seq_control.sv
module sar_seq_control
  import sar_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cclkTick,
  input  logic        startFall,
  input  logic        acqMet,
  input  logic        convLast,
  input  logic        cmdWrite,
  input  logic        chanSeqAuto,
  input  logic        autoMode,
  output seqStrobes_t strobes,
  output logic        busy,
  output logic        sampling,
  output logic        convDone,
  output logic        oscEnable
);

  seqPhase_t state, nextState;
  logic pendingQ, nextPend;
  logic finish;
  logic cmdTake;
  logic goArm;

  always_comb begin
    strobes   = '0;
    nextState = state;
    nextPend  = pendingQ;
    finish    = 1'b0;
    cmdTake   = 1'b0;
    goArm     = 1'b0;
    unique case (state)
      PH_ACQ: begin
        strobes.srcUpdate  = 1'b1;
        cmdTake            = cmdWrite & ~chanSeqAuto;
        strobes.chanLoad   = cmdTake;
        strobes.acqRestart = cmdTake;
        goArm              = (pendingQ | startFall) & acqMet & ~cmdTake;
        nextPend           = (pendingQ | startFall) & ~goArm;
        if (goArm) begin
          nextState           = PH_ARMED;
          strobes.clearToggle = 1'b1;
        end
      end
      PH_ARMED: begin
        if (cclkTick) begin
          nextState       = PH_CONV;
          strobes.cntLoad = 1'b1;
        end
      end
      PH_CONV: begin
        if (cclkTick) begin
          if (convLast) begin
            nextState           = PH_ACQ;
            finish              = 1'b1;
            strobes.acqRestart  = 1'b1;
            strobes.chanAdvance = chanSeqAuto;
          end else begin
            strobes.cntInc = 1'b1;
          end
        end
      end
      default: nextState = PH_ACQ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= PH_ACQ;
      pendingQ <= 1'b0;
      convDone <= 1'b0;
    end else begin
      state    <= nextState;
      pendingQ <= nextPend;
      convDone <= finish;
    end
  end

  assign busy      = (state == PH_CONV);
  assign sampling  = (state == PH_ACQ);
  assign oscEnable = autoMode | (state != PH_ACQ);

  assert_arm_needs_acq_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((state == PH_ARMED) && $past(state == PH_ACQ)) |-> $past(acqMet));

  assert_busy_on_tick_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cclkTick));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> !convDone);

  assert_done_with_fall_R7: assert property (@(posedge clk) disable iff (!rstN)
    convDone |-> (!busy && $past(busy)));

  assert_no_pending_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state != PH_ACQ) |-> !pendingQ);

endmodule

// File: rtl/sar_clock_sequencer.sv
module sar_clock_sequencer
  import sar_seq_pkg::*;
#(
  parameter int CONV_CYCLES = 18,
  parameter int ACQ_MIN     = 3,
  parameter int NUM_CH      = 8,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sclkIn,
  input  logic            oscIn,
  input  logic            startN,
  input  logic            srcSelSerial,
  input  logic            autoMode,
  input  logic            chanSeqAuto,
  input  logic            cmdWrite,
  input  logic [CH_W-1:0] cmdChannel,
  output logic            convClk,
  output logic            oscEnable,
  output logic            busy,
  output logic            sampling,
  output logic            convDone,
  output logic [CH_W-1:0] channel
);

  seqStrobes_t strobes;
  logic cclkTick, startFall, acqMet, convLast;

  sar_seq_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .cclkTick   (cclkTick),
    .startFall  (startFall),
    .acqMet     (acqMet),
    .convLast   (convLast),
    .cmdWrite   (cmdWrite),
    .chanSeqAuto(chanSeqAuto),
    .autoMode   (autoMode),
    .strobes    (strobes),
    .busy       (busy),
    .sampling   (sampling),
    .convDone   (convDone),
    .oscEnable  (oscEnable)
  );

  sar_seq_datapath #(
    .CONV_CYCLES(CONV_CYCLES),
    .ACQ_MIN    (ACQ_MIN),
    .NUM_CH     (NUM_CH)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .sclkIn      (sclkIn),
    .oscIn       (oscIn),
    .startN      (startN),
    .srcSelSerial(srcSelSerial),
    .cmdChannel  (cmdChannel),
    .strobes     (strobes),
    .oscEnable   (oscEnable),
    .cclkTick    (cclkTick),
    .startFall   (startFall),
    .acqMet      (acqMet),
    .convLast    (convLast),
    .convClk     (convClk),
    .channel     (channel)
  );

  assert_osc_while_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> oscEnable);

  assert_chan_steady_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(channel));

  assert_phase_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busy, sampling}));

endmodule

// File: tb/test_sar_clock_sequencer.sv
module test_sar_clock_sequencer;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclkIn = 1'b0, oscIn = 1'b0, startN = 1'b1;
  logic srcSelSerial = 1'b0, autoMode = 1'b0, chanSeqAuto = 1'b0, cmdWrite = 1'b0;
  logic [2:0] cmdChannel = '0;
  logic convClk, oscEnable, busy, sampling, convDone;
  logic [2:0] channel;

  int checks = 0, fails = 0, cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sar_clock_sequencer i_sar_clock_sequencer (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .oscIn(oscIn), .startN(startN),
    .srcSelSerial(srcSelSerial), .autoMode(autoMode), .chanSeqAuto(chanSeqAuto),
    .cmdWrite(cmdWrite), .cmdChannel(cmdChannel), .convClk(convClk),
    .oscEnable(oscEnable), .busy(busy), .sampling(sampling),
    .convDone(convDone), .channel(channel));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (time %0t)", req, act, exp, $time);
    end
  endtask

  // free-running source generators: serial period 4 cycles, oscillator period 6
  int sDiv = 0, oDiv = 0;
  always @(negedge clk) begin
    sDiv++; oDiv++;
    if (sDiv == 2) begin sDiv = 0; sclkIn = ~sclkIn; end
    if (oDiv == 3) begin oDiv = 0; oscIn = ~oscIn; end
  end

  // behavioural reference model plus conversion-length monitor
  int mPhase = 0, mAcq = 0, mCnt = 0, mChan = 0;
  bit mPend = 0, mTog = 0, mSrc = 0, mDone = 0, mPs = 0, mPo = 0, mPst = 1;
  bit lastBusy = 0, monSerial = 0, pS = 0, pO = 0;
  int monCount = 0;

  always @(posedge clk) begin
    bit sS, oS, stS, sRise, oRise, sFall, tick, take, go, clr, fin, expClk;
    sS = sclkIn; oS = oscIn; stS = startN;
    if (!rstN) begin
      mPhase = 0; mAcq = 0; mCnt = 0; mChan = 0; mPend = 0; mTog = 0; mSrc = 0;
      mDone = 0; mPs = 0; mPo = 0; mPst = 1;
    end else begin
      sRise = sS && !mPs; oRise = oS && !mPo; sFall = !stS && mPst;
      tick = mSrc ? (sRise && !mTog) : oRise;
      clr = 0; fin = 0;
      if (mPhase == 0) begin
        take = cmdWrite && !chanSeqAuto;
        go = (mPend || sFall) && (mAcq >= 3) && !take;
        mPend = (mPend || sFall) && !go;
        if (take) begin mAcq = 0; mChan = cmdChannel; end
        else if (tick && mAcq < 3) mAcq++;
        if (go) begin mPhase = 1; clr = 1; end
        if (clr) mTog = 0; else if (mSrc && sRise) mTog = !mTog;
        mSrc = srcSelSerial;
      end else begin
        if (mSrc && sRise) mTog = !mTog;
        if (tick) begin
          if (mPhase == 1) begin mPhase = 2; mCnt = 1; end
          else if (mCnt == 18) begin
            mPhase = 0; fin = 1; mAcq = 0;
            if (chanSeqAuto) mChan = (mChan + 1) % 8;
          end else mCnt++;
        end
      end
      mDone = fin; mPs = sS; mPo = oS; mPst = stS;
    end
    #1;
    if (rstN) begin
      expClk = mSrc ? mTog : (oscIn && (autoMode || mPhase != 0));
      check(busy == (mPhase == 2), "R7 busy", busy, mPhase == 2);
      check(sampling == (mPhase == 0), "R3 sampling", sampling, mPhase == 0);
      check(convDone == mDone, "R7 done", convDone, mDone);
      check(channel == mChan, "R11 channel", channel, mChan);
      check(oscEnable == (autoMode || mPhase != 0), "R4 oscEnable", oscEnable, autoMode || mPhase != 0);
      check(convClk == expClk, "R1 convClk", convClk, expClk);
      // conversion-length monitor at the ports
      if (!lastBusy && busy) begin
        monSerial = srcSelSerial; monCount = 0;
        if (monSerial) check(convClk == 1, "R10 first edge rising", convClk, 1);
      end else if (lastBusy) begin
        if (monSerial ? (sS && !pS) : (oS && !pO)) monCount++;
        if (!busy) check(monCount == (monSerial ? 36 : 18), "R2 conversion length",
                         monCount, monSerial ? 36 : 18);
      end
    end
    lastBusy = busy; pS = sS; pO = oS;
  end

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseStart();
    @(negedge clk) startN = 1'b0;
    waitCycles(2);
    startN = 1'b1;
  endtask

  task automatic waitBusy(input bit level, output int waited);
    waited = 0;
    while (busy !== level && waited < 1000) begin @(negedge clk); waited++; end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      finishRun();
    end
  end

  initial begin
    int w;
    waitCycles(3);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 0 && convDone == 0, "R7 reset idle", busy, 0);
    check(sampling == 1 && channel == 0, "R7 reset sampling", channel, 0);
    check(oscEnable == 0, "R4 osc off while sampling", oscEnable, 0);

    // serial source, manual channel, start right after command (held off)
    srcSelSerial = 1'b1;
    waitCycles(40);
    @(negedge clk) begin cmdWrite = 1'b1; cmdChannel = 3'd5; end
    @(negedge clk) cmdWrite = 1'b0;
    check(channel == 5, "R11 command loads channel", channel, 5);
    startN = 1'b0;
    waitBusy(1'b1, w);
    check(busy == 1, "R6 held-off start honoured", busy, 1);
    check(w >= 16, "R6 waited for sampling minimum", w, 16);
    check(w < 1000, "R5 falling edge starts", w, 0);
    // startN still low: request a second start during busy (R8)
    waitCycles(20);
    startN = 1'b1;
    pulseStart();
    waitBusy(1'b0, w);
    waitCycles(80);
    check(busy == 0 && sampling == 1, "R8 start during busy discarded", busy, 0);
    check(busy == 0, "R5 held-low start does not retrigger", busy, 0);

    // internal source, flip select mid-conversion
    srcSelSerial = 1'b0;
    waitCycles(40);
    check(oscEnable == 0, "R4 oscillator gated while idle", oscEnable, 0);
    pulseStart();
    waitBusy(1'b1, w);
    check(oscEnable == 1, "R4 oscillator on while busy", oscEnable, 1);
    srcSelSerial = 1'b1;
    waitBusy(1'b0, w);
    check(w < 1000, "R9 conversion finishes on original source", w, 0);
    srcSelSerial = 1'b0;

    // auto mode keeps oscillator on
    autoMode = 1'b1;
    waitCycles(10);
    check(oscEnable == 1, "R4 auto mode keeps oscillator on", oscEnable, 1);
    autoMode = 1'b0;

    // sequenced channels
    chanSeqAuto = 1'b1;
    srcSelSerial = 1'b1;
    waitCycles(40);
    @(negedge clk) begin cmdWrite = 1'b1; cmdChannel = 3'd1; end
    @(negedge clk) cmdWrite = 1'b0;
    check(channel == 5, "R12 command ignored in sequenced mode", channel, 5);
    for (int k = 0; k < 3; k++) begin
      pulseStart();
      waitBusy(1'b1, w);
      waitBusy(1'b0, w);
      @(negedge clk);
      check(channel == (6 + k) % 8, "R12 channel advances", channel, (6 + k) % 8);
      waitCycles(40);
    end

    waitCycles(10);
    finishRun();
  end

endmodule